// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port

This block controls an 8-bit bidirectional port that sits on a small CPU register bus. Each pin has its own mode bit and its own value bit. Together the two bits select one of four pin states: floating input, input with weak pull-up, driven low, or driven high. Every pin is set independently of the others. A third address is read-only and returns the pin levels after a two-flop synchronizer. The block drives three signals per pin toward an external pad: output enable, output value and pull-up enable.

A peripheral can take over any pin through a per-pin select. While the select is high, the peripheral supplies the pin's direction and value, and the port's own bits have no effect on the pad. A serial peripheral uses this to set its own pin directions in master or slave mode, and releasing the select hands the pin back to the registers. The input register still shows the pin level while the peripheral owns it.

In the special-purpose variant (`SPECIAL=1`, the default), the top two value bits are never stored. Writing a 1 to either of them raises a one-cycle power-mode request, and both always read back as zero. The top two mode bits become clock options: an alternate serial-clock phase and a clock-delay control.

Top module: `cfgIoPort`

## Requirements
- R1: After reset, the mode, value and pin registers read 0. Every pin then has padOe=0 and padPullUp=0, and both request outputs are low.
- R2: The bus addresses are 0 for the mode register, 1 for the value register and 2 for the pin register. Address 2 is read-only, so a write there changes neither the readback nor the pad outputs. Address 3 reads 0.
- R3: When a pin is not taken over, its mode bit m and value bit v select the pad state. m=0,v=0 gives a floating input (oe=0, pull=0). m=0,v=1 gives an input with pull-up (oe=0, pull=1). m=1 drives v push-pull (oe=1, out=v, pull=0). Pull-up and output enable are never high together.
- R4: Each pin's state depends only on its own bit position in the mode and value registers.
- R5: When altSel[i]=1, pin i takes padOe from altOe[i] and padOut from altOut[i], and padPullUp is 0. The mode and value readback stay unchanged.
- R6: The pin register returns padIn through two flops. A change on padIn becomes readable after the second rising clock edge, and not after the first.
- R7: With SPECIAL=1, a value-register write with bit 7 set pulses haltReq high for exactly the one cycle after the write edge. Bit 6 pulses idleReq in the same way. Value bits 7 and 6 always read 0.
- R8: With SPECIAL=1, mode bit 6 drives altSkPhase and mode bit 7 drives clkDelay. Pins 6 and 7 are never enabled or pulled by the registers, only by a peripheral takeover.
- R9: Clearing altSel[i] returns pin i to the register-selected state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| padIn | input | 8 | Raw pin levels from the pad |
| padOe | output | 8 | Per-pin output enable |
| padOut | output | 8 | Per-pin output value |
| padPullUp | output | 8 | Per-pin weak pull-up enable |
| altSel | input | 8 | Per-pin peripheral takeover select |
| altOe | input | 8 | Peripheral output enable |
| altOut | input | 8 | Peripheral output value |
| haltReq | output | 1 | One-cycle halt request |
| idleReq | output | 1 | One-cycle idle request |
| altSkPhase | output | 1 | Alternate serial clock phase select |
| clkDelay | output | 1 | Clock delay control |

## Verification
The hardest case to reach is a mixed port, where some pins are under peripheral control and the rest are under register control with different mode and value settings. Only then does a wrong mux select or a swapped bit show up in the combined pad vectors. The stimulus table loads mode and value patterns with distinct per-nibble bits and then applies partial takeover masks on top of them. Each row checks the pad outputs and confirms that the readback did not move. Directed steps then time the synchronizer edge by edge and count how many cycles each power request stays high.

// File: rtl/cfgIoPortPkg.sv
package cfgIoPortPkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_VAL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PIN  = 2'd2;

  typedef enum logic [1:0] {
    RD_MODE = 2'd0,
    RD_VAL  = 2'd1,
    RD_PIN  = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrMode;
    logic   wrVal;
    logic   haltHit;
    logic   idleHit;
    rdSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/cfgIoPortCtrl.sv
module cfgIoPortCtrl
  import cfgIoPortPkg::*;
#(
  parameter int SPECIAL = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [1:0]        wTop,
  output ctrlStrobes_t      strb
);
  localparam bit HAS_SPEC = (SPECIAL != 0);

  always_comb begin
    strb.wrMode  = busWr && (busAddr == ADDR_MODE);
    strb.wrVal   = busWr && (busAddr == ADDR_VAL);
    strb.haltHit = HAS_SPEC && strb.wrVal && wTop[1];
    strb.idleHit = HAS_SPEC && strb.wrVal && wTop[0];
    unique case (busAddr)
      ADDR_MODE: strb.rdSel = RD_MODE;
      ADDR_VAL:  strb.rdSel = RD_VAL;
      ADDR_PIN:  strb.rdSel = RD_PIN;
      default:   strb.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/cfgIoPortDp.sv
module cfgIoPortDp
  import cfgIoPortPkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int SPECIAL = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullUp,
  input  logic [WIDTH-1:0] altSel,
  input  logic [WIDTH-1:0] altOe,
  input  logic [WIDTH-1:0] altOut,
  output logic             haltReq,
  output logic             idleReq,
  output logic             altSkPhase,
  output logic             clkDelay
);
  localparam logic [WIDTH-1:0] SPEC_MASK =
    (SPECIAL != 0) ? {2'b11, {(WIDTH-2){1'b0}}} : '0;
  localparam logic [WIDTH-1:0] KEEP_MASK = ~SPEC_MASK;

  logic [WIDTH-1:0] modeReg, valReg, syncA, syncB;
  logic [WIDTH-1:0] regOe, regPull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      valReg  <= '0;
      syncA   <= '0;
      syncB   <= '0;
      haltReq <= 1'b0;
      idleReq <= 1'b0;
    end else begin
      if (strb.wrMode) modeReg <= busWdata;
      if (strb.wrVal)  valReg  <= busWdata & KEEP_MASK;
      syncA   <= padIn;
      syncB   <= syncA;
      haltReq <= strb.haltHit;
      idleReq <= strb.idleHit;
    end
  end

  assign regOe   = modeReg & KEEP_MASK;
  assign regPull = ~modeReg & valReg & KEEP_MASK;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      if (altSel[i]) begin
        padOe[i]     = altOe[i];
        padOut[i]    = altOut[i];
        padPullUp[i] = 1'b0;
      end else begin
        padOe[i]     = regOe[i];
        padOut[i]    = valReg[i];
        padPullUp[i] = regPull[i];
      end
    end
  end

  if (SPECIAL != 0) begin : g_spec
    assign altSkPhase = modeReg[WIDTH-2];
    assign clkDelay   = modeReg[WIDTH-1];
  end else begin : g_plain
    assign altSkPhase = 1'b0;
    assign clkDelay   = 1'b0;
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_MODE: busRdata = modeReg;
      RD_VAL:  busRdata = valReg;
      RD_PIN:  busRdata = syncB;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/cfgIoPort.sv
module cfgIoPort
  import cfgIoPortPkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int SPECIAL = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padPullUp,
  input  logic [WIDTH-1:0]  altSel,
  input  logic [WIDTH-1:0]  altOe,
  input  logic [WIDTH-1:0]  altOut,
  output logic              haltReq,
  output logic              idleReq,
  output logic              altSkPhase,
  output logic              clkDelay
);
  ctrlStrobes_t strb;

  cfgIoPortCtrl #(.SPECIAL(SPECIAL)) u_ctrl (
    .busAddr(busAddr),
    .busWr  (busWr),
    .wTop   (busWdata[WIDTH-1:WIDTH-2]),
    .strb   (strb)
  );

  cfgIoPortDp #(.WIDTH(WIDTH), .SPECIAL(SPECIAL)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .padPullUp (padPullUp),
    .altSel    (altSel),
    .altOe     (altOe),
    .altOut    (altOut),
    .haltReq   (haltReq),
    .idleReq   (idleReq),
    .altSkPhase(altSkPhase),
    .clkDelay  (clkDelay)
  );
endmodule

// File: rtl/cfgIoPortChk.sv
module cfgIoPortChk #(
  parameter int WIDTH   = 8,
  parameter int SPECIAL = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       busAddr,
  input logic             busWr,
  input logic [WIDTH-1:0] busWdata,
  input logic [WIDTH-1:0] busRdata,
  input logic [WIDTH-1:0] padIn,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] padPullUp,
  input logic [WIDTH-1:0] altSel,
  input logic             haltReq,
  input logic             idleReq
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R3
  pull_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padOe) == '0);

  // R5
  alt_no_pull_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & altSel) == '0);

  // R6
  pin_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && busAddr == 2'd2) |-> busRdata == $past(padIn, 2));

  if (SPECIAL != 0) begin : g_specChk
    // R7
    halt_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst != 2'd0 && haltReq) |->
        $past(busWr && busAddr == 2'd1 && busWdata[WIDTH-1]));

    // R7
    idle_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst != 2'd0 && idleReq) |->
        $past(busWr && busAddr == 2'd1 && busWdata[WIDTH-2]));

    // R7
    val_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      busAddr == 2'd1 |-> busRdata[WIDTH-1:WIDTH-2] == 2'b00);
  end
endmodule

bind cfgIoPort cfgIoPortChk #(.WIDTH(WIDTH), .SPECIAL(SPECIAL)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .padIn    (padIn),
  .padOe    (padOe),
  .padPullUp(padPullUp),
  .altSel   (altSel),
  .haltReq  (haltReq),
  .idleReq  (idleReq)
);

// File: tb/cfgIoPort_tb.sv
module cfgIoPort_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut, padPullUp;
  logic [7:0] altSel = '0, altOe = '0, altOut = '0;
  logic       haltReq, idleReq, altSkPhase, clkDelay;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgIoPort u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .padPullUp(padPullUp),
    .altSel(altSel), .altOe(altOe), .altOut(altOut),
    .haltReq(haltReq), .idleReq(idleReq),
    .altSkPhase(altSkPhase), .clkDelay(clkDelay)
  );

  // {mode, val, altSel, altOe, altOut, expOe, expOut, expPull}
  localparam logic [63:0] VEC [0:7] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3F, 8'h3F},
    {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3F, 8'h00, 8'h00},
    {8'hFF, 8'h55, 8'h00, 8'h00, 8'h00, 8'h3F, 8'h15, 8'h00},
    {8'h0F, 8'h33, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h33, 8'h30},
    {8'h0F, 8'h33, 8'hF0, 8'hA0, 8'hC0, 8'hAF, 8'hC3, 8'h00},
    {8'h05, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h05, 8'h0A, 8'h0A},
    {8'h05, 8'h0A, 8'h03, 8'h01, 8'h02, 8'h05, 8'h0A, 8'h08}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWr = 1'b1; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    check("R1 padPullUp", padPullUp, 8'h00);
    check("R1 halt/idle", {6'd0, haltReq, idleReq}, 8'h00);
    rdReg(2'd0, rd); check("R1 mode read", rd, 8'h00);
    rdReg(2'd1, rd); check("R1 val read", rd, 8'h00);
    rdReg(2'd2, rd); check("R1 pin read", rd, 8'h00);

    // R3 R4 R5 table
    for (int k = 0; k < 8; k++) begin
      wrReg(2'd0, VEC[k][63:56]);
      wrReg(2'd1, VEC[k][55:48]);
      altSel = VEC[k][47:40]; altOe = VEC[k][39:32]; altOut = VEC[k][31:24];
      #1;
      check("R3/R4/R5 padOe", padOe, VEC[k][23:16]);
      check("R3/R4/R5 padOut", padOut, VEC[k][15:8]);
      check("R3/R4/R5 padPullUp", padPullUp, VEC[k][7:0]);
      rdReg(2'd0, rd); check("R5 mode readback", rd, VEC[k][63:56]);
      rdReg(2'd1, rd); check("R7 val readback", rd, VEC[k][55:48] & 8'h3F);
    end

    // R9 release takeover returns to register state (mode 05, val 0A)
    altSel = 8'h00;
    #1;
    check("R9 padOe", padOe, 8'h05);
    check("R9 padPullUp", padPullUp, 8'h0A);

    // R2 write to pin address is ignored; address 3 reads 0
    wrReg(2'd2, 8'hFF);
    rdReg(2'd2, rd); check("R2 pin write ignored", rd, 8'h00);
    rdReg(2'd0, rd); check("R2 mode unchanged", rd, 8'h05);
    check("R2 pads unchanged", padOe, 8'h05);
    rdReg(2'd3, rd); check("R2 addr3 zero", rd, 8'h00);

    // R6 two-flop synchronizer timing
    busAddr = 2'd2;
    @(negedge clk);
    padIn = 8'hA5;
    @(negedge clk);
    rdReg(2'd2, rd); check("R6 after one edge", rd, 8'h00);
    @(negedge clk);
    rdReg(2'd2, rd); check("R6 after two edges", rd, 8'hA5);
    altSel = 8'hFF;
    @(negedge clk); @(negedge clk);
    padIn = 8'h3C;
    @(negedge clk); @(negedge clk);
    rdReg(2'd2, rd); check("R6 readable under takeover", rd, 8'h3C);
    altSel = 8'h00;

    // R7 halt and idle pulses
    wrReg(2'd1, 8'h80);
    check("R7 halt high", {6'd0, haltReq, idleReq}, 8'h02);
    @(negedge clk);
    check("R7 halt one cycle", {6'd0, haltReq, idleReq}, 8'h00);
    wrReg(2'd1, 8'h41);
    check("R7 idle high", {6'd0, haltReq, idleReq}, 8'h01);
    rdReg(2'd1, rd); check("R7 val top bits zero", rd, 8'h01);
    @(negedge clk);
    check("R7 idle one cycle", {6'd0, haltReq, idleReq}, 8'h00);

    // R8 clock option bits
    wrReg(2'd0, 8'h40);
    check("R8 altSkPhase", {6'd0, clkDelay, altSkPhase}, 8'h01);
    check("R8 pins 6/7 not driven", padOe, 8'h00);
    wrReg(2'd0, 8'h80);
    check("R8 clkDelay", {6'd0, clkDelay, altSkPhase}, 8'h02);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule